// File: doc/BRIEF.md
# Power Rail Fault and Good Sequencer

This block is the digital supervisor of a desktop power controller. Analog comparators report whether each supervised rail is under its limit, whether the 3.3 V dual rail has crossed its good threshold and whether the 1.2 V core rail is up. Around those reports it drives the ATX supply-on output, two delayed power-good outputs and the on/off choice for the USB rail. An external fault and an enabled rail under-voltage each trip a sticky latch that holds the supply off. Each latch is cleared only by a release event picked in configuration: a power-button press, or a new resume-reset assertion.

The power-good delays are counted in milliseconds. A shared prescaler turns the system clock into a 1 kHz tick, and one tick counter per output measures how long its input has been continuously good. The USB rail is switched from the current sleep state and a two-bit policy field. All inputs are taken to be synchronous to `clk`. The configuration word comes from a register bank outside this block, which also supplies the reset values of that word.

Top module: `pwrseq_supervisor`

## Requirements
- R1: While `ext_fault_n` is low, `psu_on_n` is high in the same cycle. From the next clock edge the trip is latched, and `psu_on_n` stays high after `ext_fault_n` returns high, until a release event occurs.
- R2: Under-voltage enables in `ctl_cfg`: bit 0 for `uv_pci`, bit 1 for `uv_mem`, bit 2 for `uv_dual`. An enabled under-voltage seen while the supply is on latches `psu_on_n` high from the next cycle. A disabled rail's under-voltage has no effect.
- R3: With `ctl_cfg` bit 3 set, a falling edge of `rsm_rst_n` clears both latches at the next clock edge, provided each latch's condition is absent.
- R4: With `ctl_cfg` bit 4 set, a power-button press (`pwr_btn_n` going 1 to 0 between two clock edges) clears the external-fault latch. Bit 4 alone does not clear the under-voltage latch.
- R5: With `ctl_cfg` bit 5 set, a power-button press clears the under-voltage latch. Bit 5 alone does not clear the external-fault latch.
- R6: A latch is never cleared while its condition is still present: `ext_fault_n` low for the fault latch, or any enabled under-voltage for the under-voltage latch. A press with the matching enable bit clear has no effect.
- R7: `psu_on_n` is low exactly when `on_req_n` is low, `ext_fault_n` is high and neither latch is set.
- R8: `rsm_rst_n` goes high once `dual_ok` has been continuously high for `RSM_DELAY_MS` ticks. The rise comes no earlier than (`RSM_DELAY_MS`-1)·`TICK_DIV`+1 clock edges and no later than `RSM_DELAY_MS`·`TICK_DIV`+1 clock edges after `dual_ok` is first sampled high. A drop of `dual_ok` pulls it low in the same cycle and restarts the count.
- R9: `vr_good` goes high once `core_ok` and `dual_ok` have both been continuously high for `VRG_DELAY_MS` ticks, within the same window form as R8. It is low in any cycle where `dual_ok` is low.
- R10: `usb_rail_on` is 1 in S0 (`sleep3_n`=1, `sleep5_n`=1). In S3 (`sleep3_n`=0, `sleep5_n`=1) it is 1 unless `usb_mode`=11. In S5 (`sleep5_n`=0) it is 1 only for `usb_mode` 00 or the reserved 10.
- R11: During and right after reset both latches are clear and `rsm_rst_n` and `vr_good` are low, whatever `dual_ok` and `core_ok` are.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| on_req_n | input | 1 | Power-on request, low active |
| ext_fault_n | input | 1 | External fault, low active |
| pwr_btn_n | input | 1 | Power button, low while pressed |
| sleep3_n | input | 1 | Sleep-state input, low in S3 |
| sleep5_n | input | 1 | Sleep-state input, low in S5 |
| uv_pci | input | 1 | PCI rail under-voltage comparator |
| uv_mem | input | 1 | Memory rail under-voltage comparator |
| uv_dual | input | 1 | 3.3 V dual rail under-voltage comparator |
| dual_ok | input | 1 | 3.3 V dual rail above its good threshold |
| core_ok | input | 1 | 1.2 V sense above its good threshold |
| ctl_cfg | input | 6 | Under-voltage enables and release selects |
| usb_mode | input | 2 | USB rail policy |
| psu_on_n | output | 1 | ATX supply-on control, low active |
| rsm_rst_n | output | 1 | Resume reset, high when released |
| vr_good | output | 1 | Core regulator good |
| usb_rail_on | output | 1 | USB rail enable |

## Verification
`psu_on_n` follows a request or an external fault in the same cycle. A latch set by an under-voltage, or cleared by a press or by a resume-reset fall, shows at `psu_on_n` one clock edge after the event. The bench drives inputs just after the falling clock edge and compares shortly after that, so each result is read after the rising edge at which it is due. The timer outputs depend on where the prescaler is in its cycle when the input rises. The bench therefore checks both ends of the window: low after (D-1)·P edges and high after D·P+1 edges. A bench model of the two latches tracks a long random run of requests, faults, under-voltages, presses and configurations, step by step.

// File: rtl/pwrseq_pkg.sv
package pwrseq_pkg;

  localparam int CFG_W       = 6;
  localparam int CFG_UV_PCI  = 0;
  localparam int CFG_UV_MEM  = 1;
  localparam int CFG_UV_DUAL = 2;
  localparam int CFG_REL_RSM = 3;
  localparam int CFG_REL_FLT = 4;
  localparam int CFG_REL_UV  = 5;
  localparam int N_UV        = 3;
  localparam int N_LATCH     = 2;
  localparam int LAT_FLT     = 0;
  localparam int LAT_UV      = 1;

  typedef enum logic [1:0] {
    ST_S0 = 2'd0,
    ST_S3 = 2'd1,
    ST_S5 = 2'd2
  } sleep_st_e;

  typedef enum logic [1:0] {
    USB_ALL  = 2'b00,
    USB_S0S3 = 2'b01,
    USB_RSVD = 2'b10,
    USB_S0   = 2'b11
  } usb_mode_e;

endpackage

// File: rtl/pwrseq_trip_latch.sv
module pwrseq_trip_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic trip_i,
  input  logic cond_i,
  input  logic release_i,
  output logic tripped_o
);

  logic lat_q;
  logic lat_d;

  // trip has priority; release only once the condition is gone
  always_comb begin
    lat_d = lat_q;
    if (trip_i) begin
      lat_d = 1'b1;
    end else if (lat_q && release_i && !cond_i) begin
      lat_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lat_q <= 1'b0;
    end else begin
      lat_q <= lat_d;
    end
  end

  assign tripped_o = lat_q;

endmodule

// File: rtl/pwrseq_ms_timer.sv
module pwrseq_ms_timer #(
  parameter int unsigned DELAY_MS = 82
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick_i,
  input  logic level_i,
  output logic done_o
);

  localparam int unsigned CW = $clog2(DELAY_MS + 1);
  localparam logic [CW-1:0] TERM = CW'(DELAY_MS);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_d;
  logic          cnt_en;

  assign cnt_en = tick_i && (cnt_q != TERM);

  always_comb begin
    cnt_d = cnt_q;
    if (!level_i) begin
      cnt_d = '0;
    end else if (cnt_en) begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_d;
    end
  end

  assign done_o = level_i && (cnt_q == TERM);

endmodule

// File: rtl/pwrseq_usb_sel.sv
module pwrseq_usb_sel
  import pwrseq_pkg::*;
(
  input  logic       sleep3_n,
  input  logic       sleep5_n,
  input  logic [1:0] mode_i,
  output logic       rail_on_o
);

  sleep_st_e st;
  usb_mode_e mode;

  assign mode = usb_mode_e'(mode_i);

  always_comb begin
    if (!sleep5_n) begin
      st = ST_S5;
    end else if (!sleep3_n) begin
      st = ST_S3;
    end else begin
      st = ST_S0;
    end
  end

  always_comb begin
    unique case (st)
      ST_S0:   rail_on_o = 1'b1;
      ST_S3:   rail_on_o = (mode != USB_S0);
      default: rail_on_o = (mode == USB_ALL) || (mode == USB_RSVD);
    endcase
  end

endmodule

// File: rtl/pwrseq_supervisor.sv
module pwrseq_supervisor
  import pwrseq_pkg::*;
#(
  parameter int unsigned TICK_DIV     = 125000,
  parameter int unsigned RSM_DELAY_MS = 82,
  parameter int unsigned VRG_DELAY_MS = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             on_req_n,
  input  logic             ext_fault_n,
  input  logic             pwr_btn_n,
  input  logic             sleep3_n,
  input  logic             sleep5_n,
  input  logic             uv_pci,
  input  logic             uv_mem,
  input  logic             uv_dual,
  input  logic             dual_ok,
  input  logic             core_ok,
  input  logic [CFG_W-1:0] ctl_cfg,
  input  logic [1:0]       usb_mode,
  output logic             psu_on_n,
  output logic             rsm_rst_n,
  output logic             vr_good,
  output logic             usb_rail_on
);

  localparam int unsigned PW = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
  localparam logic [PW-1:0] PRE_LAST = PW'(TICK_DIV - 1);

  // 1 kHz tick prescaler
  logic [PW-1:0] pre_q;
  logic [PW-1:0] pre_d;
  logic          ms_tick;

  assign ms_tick = (pre_q == PRE_LAST);

  always_comb begin
    pre_d = ms_tick ? '0 : pre_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_q <= '0;
    end else begin
      pre_q <= pre_d;
    end
  end

  // release edge detection
  logic btn_prev_q;
  logic rsm_prev_q;
  logic btn_fall;
  logic rsm_fall;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      btn_prev_q <= 1'b1;
      rsm_prev_q <= 1'b0;
    end else begin
      btn_prev_q <= pwr_btn_n;
      rsm_prev_q <= rsm_rst_n;
    end
  end

  assign btn_fall = btn_prev_q && !pwr_btn_n;
  assign rsm_fall = rsm_prev_q && !rsm_rst_n;

  // trip latches
  logic [N_UV-1:0]    uv_vec;
  logic               uv_hit;
  logic               supply_on;
  logic [N_LATCH-1:0] lat_trip;
  logic [N_LATCH-1:0] lat_cond;
  logic [N_LATCH-1:0] lat_rel;
  logic [N_LATCH-1:0] lat_q;
  logic               fault_lat;
  logic               uv_lat;

  assign uv_vec    = {uv_dual, uv_mem, uv_pci};
  assign uv_hit    = |(uv_vec & ctl_cfg[CFG_UV_DUAL:CFG_UV_PCI]);
  assign supply_on = !on_req_n && ext_fault_n && !(|lat_q);

  always_comb begin
    lat_trip[LAT_FLT] = !ext_fault_n;
    lat_cond[LAT_FLT] = !ext_fault_n;
    lat_rel[LAT_FLT]  = (btn_fall && ctl_cfg[CFG_REL_FLT]) ||
                        (rsm_fall && ctl_cfg[CFG_REL_RSM]);
    lat_trip[LAT_UV]  = uv_hit && supply_on;
    lat_cond[LAT_UV]  = uv_hit;
    lat_rel[LAT_UV]   = (btn_fall && ctl_cfg[CFG_REL_UV]) ||
                        (rsm_fall && ctl_cfg[CFG_REL_RSM]);
  end

  for (genvar g = 0; g < N_LATCH; g++) begin : g_latch
    pwrseq_trip_latch u_latch (
      .clk       (clk),
      .rst_n     (rst_n),
      .trip_i    (lat_trip[g]),
      .cond_i    (lat_cond[g]),
      .release_i (lat_rel[g]),
      .tripped_o (lat_q[g])
    );
  end

  assign fault_lat = lat_q[LAT_FLT];
  assign uv_lat    = lat_q[LAT_UV];
  assign psu_on_n  = !supply_on;

  // delayed power-good outputs
  pwrseq_ms_timer #(.DELAY_MS(RSM_DELAY_MS)) u_rsm_tmr (
    .clk     (clk),
    .rst_n   (rst_n),
    .tick_i  (ms_tick),
    .level_i (dual_ok),
    .done_o  (rsm_rst_n)
  );

  pwrseq_ms_timer #(.DELAY_MS(VRG_DELAY_MS)) u_vrg_tmr (
    .clk     (clk),
    .rst_n   (rst_n),
    .tick_i  (ms_tick),
    .level_i (dual_ok && core_ok),
    .done_o  (vr_good)
  );

  pwrseq_usb_sel u_usb (
    .sleep3_n  (sleep3_n),
    .sleep5_n  (sleep5_n),
    .mode_i    (usb_mode),
    .rail_on_o (usb_rail_on)
  );

endmodule

// File: rtl/pwrseq_supervisor_sva.sv
module pwrseq_supervisor_sva (
  input logic       clk,
  input logic       rst_n,
  input logic       on_req_n,
  input logic       ext_fault_n,
  input logic       sleep3_n,
  input logic       sleep5_n,
  input logic       uv_pci,
  input logic       uv_mem,
  input logic       uv_dual,
  input logic       dual_ok,
  input logic [5:0] ctl_cfg,
  input logic [1:0] usb_mode,
  input logic       psu_on_n,
  input logic       rsm_rst_n,
  input logic       vr_good,
  input logic       usb_rail_on,
  input logic       fault_q,
  input logic       uv_q
);

  a_r1_fault_forces_off: assert property (@(posedge clk) disable iff (!rst_n)
    !ext_fault_n |-> psu_on_n);

  a_r1_latch_holds_off: assert property (@(posedge clk) disable iff (!rst_n)
    fault_q |-> psu_on_n);

  a_r2_uv_latch_holds_off: assert property (@(posedge clk) disable iff (!rst_n)
    uv_q |-> psu_on_n);

  a_r6_fault_release_clean: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(fault_q) |-> $past(ext_fault_n));

  a_r6_uv_release_clean: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(uv_q) |-> (($past({uv_dual, uv_mem, uv_pci}) & $past(ctl_cfg[2:0])) == 3'b000));

  a_r7_request_grants: assert property (@(posedge clk) disable iff (!rst_n)
    (!on_req_n && ext_fault_n && !fault_q && !uv_q) |-> !psu_on_n);

  a_r8_rsm_needs_dual: assert property (@(posedge clk) disable iff (!rst_n)
    !dual_ok |-> !rsm_rst_n);

  a_r8_rsm_rise_after_good: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rsm_rst_n) |-> $past(dual_ok));

  a_r9_vrg_needs_dual: assert property (@(posedge clk) disable iff (!rst_n)
    !dual_ok |-> !vr_good);

  a_r10_usb_s0_on: assert property (@(posedge clk) disable iff (!rst_n)
    (sleep3_n && sleep5_n) |-> usb_rail_on);

  a_r10_usb_s5_off: assert property (@(posedge clk) disable iff (!rst_n)
    (!sleep5_n && usb_mode[0]) |-> !usb_rail_on);

endmodule

bind pwrseq_supervisor pwrseq_supervisor_sva u_sva (
  .clk         (clk),
  .rst_n       (rst_n),
  .on_req_n    (on_req_n),
  .ext_fault_n (ext_fault_n),
  .sleep3_n    (sleep3_n),
  .sleep5_n    (sleep5_n),
  .uv_pci      (uv_pci),
  .uv_mem      (uv_mem),
  .uv_dual     (uv_dual),
  .dual_ok     (dual_ok),
  .ctl_cfg     (ctl_cfg),
  .usb_mode    (usb_mode),
  .psu_on_n    (psu_on_n),
  .rsm_rst_n   (rsm_rst_n),
  .vr_good     (vr_good),
  .usb_rail_on (usb_rail_on),
  .fault_q     (fault_lat),
  .uv_q        (uv_lat)
);

// File: tb/pwrseq_supervisor_bench.sv
`timescale 1ns/1ps
module pwrseq_supervisor_bench;

  localparam int DIV    = 4;
  localparam int RSM_MS = 82;
  localparam int VRG_MS = 2;
  localparam int WD_MAX = 100000;

  logic       clk;
  logic       rst_n;
  logic       on_req_n, ext_fault_n, pwr_btn_n, sleep3_n, sleep5_n;
  logic       uv_pci, uv_mem, uv_dual, dual_ok, core_ok;
  logic [5:0] ctl_cfg;
  logic [1:0] usb_mode;
  logic       psu_on_n, rsm_rst_n, vr_good, usb_rail_on;

  int n_total = 0;
  int n_fail  = 0;
  int wd      = 0;

  pwrseq_supervisor #(
    .TICK_DIV     (DIV),
    .RSM_DELAY_MS (RSM_MS),
    .VRG_DELAY_MS (VRG_MS)
  ) u_pwrseq_supervisor (
    .clk         (clk),
    .rst_n       (rst_n),
    .on_req_n    (on_req_n),
    .ext_fault_n (ext_fault_n),
    .pwr_btn_n   (pwr_btn_n),
    .sleep3_n    (sleep3_n),
    .sleep5_n    (sleep5_n),
    .uv_pci      (uv_pci),
    .uv_mem      (uv_mem),
    .uv_dual     (uv_dual),
    .dual_ok     (dual_ok),
    .core_ok     (core_ok),
    .ctl_cfg     (ctl_cfg),
    .usb_mode    (usb_mode),
    .psu_on_n    (psu_on_n),
    .rsm_rst_n   (rsm_rst_n),
    .vr_good     (vr_good),
    .usb_rail_on (usb_rail_on)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic summary();
    $display("%0d/%0d checks passed", n_total - n_fail, n_total);
  endtask

  always @(posedge clk) begin
    wd++;
    if (wd == WD_MAX) begin
      n_total++;
      n_fail++;
      $display("FAIL watchdog: actual=%0d cycles expected=<%0d", wd, WD_MAX);
      summary();
      $finish;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_total++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
    #1;
  endtask

  function automatic logic exp_usb(input logic s3n, input logic s5n, input logic [1:0] m);
    if (!s5n)      return (m == 2'b00) || (m == 2'b10);
    else if (!s3n) return (m != 2'b11);
    else           return 1'b1;
  endfunction

  task automatic press();
    pwr_btn_n = 1'b1;
    step(1);
    pwr_btn_n = 1'b0;
    step(1);
    pwr_btn_n = 1'b1;
    #1;
  endtask

  logic m_flt, m_uv, prev_btn, m_on, uvh, bfall;

  initial begin
    void'($urandom(32'd20240611));
    rst_n = 1'b0;
    on_req_n = 1'b1; ext_fault_n = 1'b1; pwr_btn_n = 1'b1;
    sleep3_n = 1'b1; sleep5_n = 1'b1;
    uv_pci = 1'b0; uv_mem = 1'b0; uv_dual = 1'b0;
    dual_ok = 1'b1; core_ok = 1'b1;
    ctl_cfg = 6'h07; usb_mode = 2'b00;
    step(5);
    chk("R11 rsm_rst_n held in reset", rsm_rst_n, 1'b0);
    chk("R11 vr_good held in reset", vr_good, 1'b0);
    chk("R11 psu off without request", psu_on_n, 1'b1);
    dual_ok = 1'b0; core_ok = 1'b0;
    step(1);
    rst_n = 1'b1;
    step(2);
    chk("R11 rsm_rst_n low after reset", rsm_rst_n, 1'b0);
    on_req_n = 1'b0;
    #1;
    chk("R7 request turns supply on", psu_on_n, 1'b0);

    // random phase against a bench latch model
    m_flt = 1'b0; m_uv = 1'b0; prev_btn = 1'b1;
    for (int i = 0; i < 600; i++) begin
      on_req_n    = ($urandom % 8) == 0;
      ext_fault_n = ($urandom % 16) != 0;
      pwr_btn_n   = ($urandom % 4) != 0;
      uv_pci      = ($urandom % 12) == 0;
      uv_mem      = ($urandom % 12) == 0;
      uv_dual     = ($urandom % 12) == 0;
      ctl_cfg     = 6'($urandom) & 6'h37;
      sleep3_n    = 1'($urandom);
      sleep5_n    = 1'($urandom);
      usb_mode    = 2'($urandom);
      #1;
      m_on = !on_req_n && ext_fault_n && !m_flt && !m_uv;
      chk("R7 random supply state (R1 R2 R4 R5 R6)", psu_on_n, !m_on);
      chk("R10 random USB decode", usb_rail_on, exp_usb(sleep3_n, sleep5_n, usb_mode));
      uvh   = |({uv_dual, uv_mem, uv_pci} & ctl_cfg[2:0]);
      bfall = prev_btn && !pwr_btn_n;
      if (!ext_fault_n)                        m_flt = 1'b1;
      else if (m_flt && bfall && ctl_cfg[4])   m_flt = 1'b0;
      if (uvh && m_on)                         m_uv = 1'b1;
      else if (m_uv && bfall && ctl_cfg[5] && !uvh) m_uv = 1'b0;
      prev_btn = pwr_btn_n;
      step(1);
    end

    // clean up: clear both latches
    on_req_n = 1'b0; ext_fault_n = 1'b1; uv_pci = 1'b0; uv_mem = 1'b0; uv_dual = 1'b0;
    sleep3_n = 1'b1; sleep5_n = 1'b1; ctl_cfg = 6'h37;
    press();
    step(1);
    chk("R4 R5 press clears both latches", psu_on_n, 1'b0);

    // R1 / R6 / R4 directed
    ctl_cfg = 6'h07;
    ext_fault_n = 1'b0;
    #1;
    chk("R1 fault forces off same cycle", psu_on_n, 1'b1);
    step(1);
    ext_fault_n = 1'b1;
    step(3);
    chk("R1 fault stays latched", psu_on_n, 1'b1);
    press();
    step(1);
    chk("R6 press without enable ignored", psu_on_n, 1'b1);
    ctl_cfg = 6'h27;
    press();
    step(1);
    chk("R5 uv release bit does not clear fault", psu_on_n, 1'b1);
    ctl_cfg = 6'h17;
    ext_fault_n = 1'b0;
    press();
    ext_fault_n = 1'b1;
    step(1);
    chk("R6 press while fault present ignored", psu_on_n, 1'b1);
    press();
    step(1);
    chk("R4 press clears fault latch", psu_on_n, 1'b0);

    // R2 / R5 directed
    ctl_cfg = 6'h02;
    uv_pci = 1'b1;
    step(3);
    chk("R2 disabled rail under-voltage ignored", psu_on_n, 1'b0);
    uv_pci = 1'b0;
    uv_mem = 1'b1;
    #1;
    chk("R2 enabled under-voltage not yet latched", psu_on_n, 1'b0);
    step(1);
    chk("R2 enabled under-voltage latches off", psu_on_n, 1'b1);
    uv_mem = 1'b0;
    ctl_cfg = 6'h12;
    press();
    step(1);
    chk("R4 fault release bit does not clear uv", psu_on_n, 1'b1);
    ctl_cfg = 6'h22;
    uv_mem = 1'b1;
    press();
    uv_mem = 1'b0;
    step(1);
    chk("R6 press while uv present ignored", psu_on_n, 1'b1);
    press();
    step(1);
    chk("R5 press clears uv latch", psu_on_n, 1'b0);

    // R8 window
    ctl_cfg = 6'h07;
    dual_ok = 1'b1;
    step((RSM_MS - 1) * DIV);
    chk("R8 rsm_rst_n not early", rsm_rst_n, 1'b0);
    step(DIV + 1);
    chk("R8 rsm_rst_n released by deadline", rsm_rst_n, 1'b1);
    // restart
    dual_ok = 1'b0;
    #1;
    chk("R8 rsm_rst_n drops with dual_ok", rsm_rst_n, 1'b0);
    step(1);
    dual_ok = 1'b1;
    step(40 * DIV);
    dual_ok = 1'b0;
    step(1);
    dual_ok = 1'b1;
    step((RSM_MS - 1) * DIV);
    chk("R8 count restarted after drop", rsm_rst_n, 1'b0);
    step(DIV + 1);
    chk("R8 release after restart", rsm_rst_n, 1'b1);

    // R9 window
    core_ok = 1'b1;
    step((VRG_MS - 1) * DIV);
    chk("R9 vr_good not early", vr_good, 1'b0);
    step(DIV + 1);
    chk("R9 vr_good by deadline", vr_good, 1'b1);

    // R3: uv then fault latched, resume-reset fall clears both
    ctl_cfg = 6'h0F;
    uv_dual = 1'b1;
    step(1);
    uv_dual = 1'b0;
    ext_fault_n = 1'b0;
    step(1);
    ext_fault_n = 1'b1;
    step(2);
    chk("R3 both latched before restart", psu_on_n, 1'b1);
    dual_ok = 1'b0;
    #1;
    chk("R9 vr_good low with dual_ok low", vr_good, 1'b0);
    chk("R8 rsm_rst_n low with dual_ok low", rsm_rst_n, 1'b0);
    step(1);
    chk("R3 resume-reset fall clears latches", psu_on_n, 1'b0);

    // R10 exhaustive
    for (int s = 0; s < 3; s++) begin
      for (int m = 0; m < 4; m++) begin
        sleep3_n = (s == 0);
        sleep5_n = (s != 2);
        usb_mode = 2'(m);
        #1;
        chk("R10 USB decode table", usb_rail_on, exp_usb(sleep3_n, sleep5_n, usb_mode));
      end
    end

    summary();
    $finish;
  end

endmodule